// File: doc/BRIEF.md
# Multi-Channel Transfer Event Flag Unit

This block gathers the per-channel transfer events of a multi-channel DMA engine (half-way point reached, transfer complete, transfer error) into sticky flags. All flags are packed into one readable status word. Software removes flags by writing ones to a separate clear address. Each channel drives its own interrupt line, gated by a four-bit enable mask that the channel's configuration logic supplies. A cause decoder reports one prioritised reason for a selected channel, so a handler can tell what happened without decoding the status word itself.

The DMA datapath stays outside. The engine pulses the event inputs, which may be asserted on any cycle, independently of the enables. The status and clear registers sit behind a minimal write-strobe and address register port. Reads of that port are combinational.

Top module: `dma_evt_flag_unit`

## Requirements
- R1: An event input high at a clock edge sets the matching sticky flag after that edge, whatever the channel's enable mask holds.
- R2: Channel c (0-based) owns status bits 4c+3..4c: bit 4c+1 is complete, bit 4c+2 is half-transfer, bit 4c+3 is error, and bit 4c (summary) reads as the OR of the other three.
- R3: A write to the clear address (bus_addr = 1) clears each complete/half/error flag whose bit position is written as 1; positions written as 0 keep their flag.
- R4: Writing 1 to a channel's summary position (bit 4c) at the clear address clears all three of that channel's flags.
- R5: When an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: irq[c] is high exactly when some bit of channel c's status nibble is 1 and the same bit of int_en[4c+3:4c] is 1; enable bit 0 therefore fires on any flag of the channel.
- R7: Clearing a channel's four enable bits drops irq[c] but leaves its flags set and readable.
- R8: cause_code for channel cause_sel is 3 if its error flag is set, else 2 if complete is set, else 1 if half is set, else 0; a cause_sel of NUM_CH or above yields 0.
- R9: Read data bits above 4*NUM_CH-1 are zero. Reading the clear address returns zero. A write to the status address (bus_addr = 0) changes no flag.
- R10: While rst_n is low at a clock edge, all flags clear and every irq line is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_half | input | NUM_CH | Half-transfer event, one bit per channel |
| ev_done | input | NUM_CH | Transfer-complete event, one bit per channel |
| ev_err | input | NUM_CH | Transfer-error event, one bit per channel |
| int_en | input | 4*NUM_CH | Per-channel interrupt enable nibbles, same layout as the status word |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = status word, 1 = clear word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| cause_sel | input | SEL_W | Channel whose cause is decoded |
| cause_code | output | 2 | 0 none, 1 half, 2 complete, 3 error |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
On every cycle, the assertions check three things. A flag never drops without a clear write in the cycle before. An event always leaves its flag set, even against a simultaneous clear. An interrupt line never rises for a channel whose enable nibble is zero. They also check the zero padding and the out-of-range cause code. Other behaviours can only be shown by the bench's reference model and scenarios: the exact nibble positions, which flags a given clear pattern removes, the summary-bit clear of a whole channel, and the error-over-complete-over-half precedence.

// File: rtl/dma_evt_flag_pkg.sv
// Shared constants and types of the event flag unit.
// Assumes a four-bit nibble per channel in the status and clear words.
package dma_evt_flag_pkg;
    localparam int NIB_W   = 4;
    localparam int POS_SUM = 0;
    localparam int POS_DONE = 1;
    localparam int POS_HALF = 2;
    localparam int POS_ERR  = 3;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_HALF = 2'd1,
        CAUSE_DONE = 2'd2,
        CAUSE_ERR  = 2'd3
    } cause_e;
endpackage

// File: rtl/dma_evt_chan_slice.sv
// One channel's sticky flags and its interrupt line.
// Assumes clr_nib is already qualified by a write to the clear address.
// An event in the same cycle as a clear leaves the flag set.
module dma_evt_chan_slice
    import dma_evt_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic             ev_half,
    input  logic             ev_err,
    input  logic [NIB_W-1:0] clr_nib,
    input  logic [NIB_W-1:0] en_nib,
    output logic             done_q,
    output logic             half_q,
    output logic             err_q,
    output logic [NIB_W-1:0] stat_nib,
    output logic             irq
);
    logic kill_all;

    // Purpose: a summary-position clear removes every flag of the channel.
    assign kill_all = clr_nib[POS_SUM];

    // Purpose: set on event, otherwise drop on a matching clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            half_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= ev_done | (done_q & ~(kill_all | clr_nib[POS_DONE]));
            half_q <= ev_half | (half_q & ~(kill_all | clr_nib[POS_HALF]));
            err_q  <= ev_err  | (err_q  & ~(kill_all | clr_nib[POS_ERR]));
        end
    end

    // Purpose: pack the nibble with the summary bit and gate the interrupt.
    always_comb begin
        stat_nib           = '0;
        stat_nib[POS_DONE] = done_q;
        stat_nib[POS_HALF] = half_q;
        stat_nib[POS_ERR]  = err_q;
        stat_nib[POS_SUM]  = done_q | half_q | err_q;
        irq                = |(stat_nib & en_nib);
    end
endmodule

// File: rtl/dma_evt_reg_port.sv
// Register port: status read-back and the write-one-to-clear decode.
// Assumes address 0 holds the read-only status word and address 1 the clear word.
module dma_evt_reg_port #(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 28
) (
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [FLAG_W-1:0] stat_flat,
    output logic [FLAG_W-1:0] clr_flat,
    output logic [DATA_W-1:0] bus_rdata
);
    // Purpose: only a write to the clear address produces clear strobes.
    always_comb begin
        clr_flat = (bus_wr && bus_addr) ? bus_wdata[FLAG_W-1:0] : '0;
    end

    // Purpose: status word zero-padded; the clear address reads as zero.
    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[FLAG_W-1:0] = stat_flat;
        end
    end

    generate
        if (DATA_W > FLAG_W) begin : g_pad
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[DATA_W-1:FLAG_W];
        end
    endgenerate
endmodule

// File: rtl/dma_evt_cause_dec.sv
// Prioritised cause decoder for one selected channel.
// Precedence: error, then complete, then half; an unknown channel gives none.
module dma_evt_cause_dec
    import dma_evt_flag_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int SEL_W  = 3
) (
    input  logic [NUM_CH-1:0] done_v,
    input  logic [NUM_CH-1:0] half_v,
    input  logic [NUM_CH-1:0] err_v,
    input  logic [SEL_W-1:0]  cause_sel,
    output cause_e            cause
);
    // Purpose: pick the selected channel's flags, then apply the fixed precedence.
    always_comb begin
        logic d;
        logic h;
        logic e;
        d = 1'b0;
        h = 1'b0;
        e = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(cause_sel) == c) begin
                d = done_v[c];
                h = half_v[c];
                e = err_v[c];
            end
        end
        if (e)      cause = CAUSE_ERR;
        else if (d) cause = CAUSE_DONE;
        else if (h) cause = CAUSE_HALF;
        else        cause = CAUSE_NONE;
    end
endmodule

// File: rtl/dma_evt_flag_unit.sv
// Top of the event flag unit: one slice per channel, the register port
// and the cause decoder. Assumes 4*NUM_CH <= DATA_W and NUM_CH < 2**SEL_W.
module dma_evt_flag_unit
    import dma_evt_flag_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ev_half,
    input  logic [NUM_CH-1:0]       ev_done,
    input  logic [NUM_CH-1:0]       ev_err,
    input  logic [NIB_W*NUM_CH-1:0] int_en,
    input  logic                    bus_wr,
    input  logic                    bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [SEL_W-1:0]        cause_sel,
    output logic [1:0]              cause_code,
    output logic [NUM_CH-1:0]       irq
);
    localparam int FLAG_W = NIB_W * NUM_CH;

    logic [FLAG_W-1:0] stat_flat;
    logic [FLAG_W-1:0] clr_flat;
    logic [NUM_CH-1:0] done_v;
    logic [NUM_CH-1:0] half_v;
    logic [NUM_CH-1:0] err_v;
    cause_e            cause;

    // Purpose: one flag slice per channel, nibble c at bits 4c+3..4c.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dma_evt_chan_slice u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .ev_done  (ev_done[c]),
                .ev_half  (ev_half[c]),
                .ev_err   (ev_err[c]),
                .clr_nib  (clr_flat[NIB_W*c +: NIB_W]),
                .en_nib   (int_en[NIB_W*c +: NIB_W]),
                .done_q   (done_v[c]),
                .half_q   (half_v[c]),
                .err_q    (err_v[c]),
                .stat_nib (stat_flat[NIB_W*c +: NIB_W]),
                .irq      (irq[c])
            );
        end
    endgenerate

    dma_evt_reg_port #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_regs (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_flat (stat_flat),
        .clr_flat  (clr_flat),
        .bus_rdata (bus_rdata)
    );

    dma_evt_cause_dec #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_cause (
        .done_v    (done_v),
        .half_v    (half_v),
        .err_v     (err_v),
        .cause_sel (cause_sel),
        .cause     (cause)
    );

    // Purpose: expose the decoded cause as a plain two-bit code.
    assign cause_code = cause;
endmodule

// File: rtl/dma_evt_flag_unit_chk.sv
// Assertion checker for the event flag unit, bound to the top module.
module dma_evt_flag_unit_chk #(
    parameter int NUM_CH = 7,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   ev_half,
    input logic [NUM_CH-1:0]   ev_done,
    input logic [NUM_CH-1:0]   ev_err,
    input logic [4*NUM_CH-1:0] int_en,
    input logic                bus_wr,
    input logic                bus_addr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [SEL_W-1:0]    cause_sel,
    input logic [1:0]          cause_code,
    input logic [NUM_CH-1:0]   irq,
    input logic [NUM_CH-1:0]   done_v,
    input logic [NUM_CH-1:0]   half_v,
    input logic [NUM_CH-1:0]   err_v
);
    logic [NUM_CH-1:0] en_any;

    // Purpose: per-channel "any enable bit set" for the masking check.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            en_any[c] = |int_en[4*c +: 4];
        end
    end

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((done_v & $past(ev_done)) == $past(ev_done)) &&
                   ((half_v & $past(ev_half)) == $past(ev_half)) &&
                   ((err_v  & $past(ev_err))  == $past(ev_err)))); // R1 R5

    AST_FLAG_HOLDS_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr) |=> (((done_v & $past(done_v)) == $past(done_v)) &&
                                   ((half_v & $past(half_v)) == $past(half_v)) &&
                                   ((err_v  & $past(err_v))  == $past(err_v)))); // R3

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~en_any) == '0)); // R7

    AST_CAUSE_UNKNOWN_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cause_sel) >= NUM_CH) |-> (cause_code == 2'd0)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq == '0)); // R10

    generate
        if (DATA_W > 4*NUM_CH) begin : g_pad
            AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_rdata[DATA_W-1:4*NUM_CH] == '0)); // R9
        end
    endgenerate
endmodule

bind dma_evt_flag_unit dma_evt_flag_unit_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_half    (ev_half),
    .ev_done    (ev_done),
    .ev_err     (ev_err),
    .int_en     (int_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .cause_sel  (cause_sel),
    .cause_code (cause_code),
    .irq        (irq),
    .done_v     (done_v),
    .half_v     (half_v),
    .err_v      (err_v)
);

// File: tb/dma_evt_flag_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed scenarios.
module dma_evt_flag_unit_tb_top;
    localparam int NC = 7;
    localparam int DW = 32;
    localparam int SW = 3;
    localparam int FW = 4 * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ev_half = '0;
    logic [NC-1:0] ev_done = '0;
    logic [NC-1:0] ev_err = '0;
    logic [FW-1:0] int_en = '0;
    logic          bus_wr = 1'b0;
    logic          bus_addr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [SW-1:0] cause_sel = '0;
    logic [1:0]    cause_code;
    logic [NC-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference state: one bit per channel and flag kind.
    bit m_done[NC];
    bit m_half[NC];
    bit m_err[NC];

    always #2.5 clk = ~clk;

    dma_evt_flag_unit #(.NUM_CH(NC), .DATA_W(DW), .SEL_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_half(ev_half), .ev_done(ev_done), .ev_err(ev_err),
        .int_en(int_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cause_sel(cause_sel), .cause_code(cause_code), .irq(irq)
    );

    function automatic logic [DW-1:0] model_status();
        logic [DW-1:0] w = '0;
        for (int c = 0; c < NC; c++) begin
            w[4*c+1] = m_done[c];
            w[4*c+2] = m_half[c];
            w[4*c+3] = m_err[c];
            w[4*c]   = m_done[c] | m_half[c] | m_err[c];
        end
        return w;
    endfunction

    function automatic logic [NC-1:0] model_irq();
        logic [DW-1:0] s = model_status();
        logic [NC-1:0] r = '0;
        for (int c = 0; c < NC; c++) begin
            for (int b = 0; b < 4; b++) begin
                if (s[4*c+b] && int_en[4*c+b]) r[c] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [1:0] model_cause();
        int s = int'(cause_sel);
        if (s >= NC) return 2'd0;
        if (m_err[s])  return 2'd3;
        if (m_done[s]) return 2'd2;
        if (m_half[s]) return 2'd1;
        return 2'd0;
    endfunction

    // Clock-edge update of the reference, from the inputs held over the edge.
    task automatic model_step();
        for (int c = 0; c < NC; c++) begin
            if (!rst_n) begin
                m_done[c] = 0; m_half[c] = 0; m_err[c] = 0;
            end else begin
                if (bus_wr && bus_addr) begin
                    if (bus_wdata[4*c] || bus_wdata[4*c+1]) m_done[c] = 0;
                    if (bus_wdata[4*c] || bus_wdata[4*c+2]) m_half[c] = 0;
                    if (bus_wdata[4*c] || bus_wdata[4*c+3]) m_err[c]  = 0;
                end
                if (ev_done[c]) m_done[c] = 1;
                if (ev_half[c]) m_half[c] = 1;
                if (ev_err[c])  m_err[c]  = 1;
            end
        end
    endtask

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        logic [DW-1:0] exp_rd = bus_addr ? '0 : model_status();
        check({tag, " R6 irq"}, DW'(irq), DW'(model_irq()));
        check({tag, " R2 R9 rdata"}, bus_rdata, exp_rd);
        check({tag, " R8 cause"}, DW'(cause_code), DW'(model_cause()));
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_inputs();
        ev_half = '0; ev_done = '0; ev_err = '0;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin m_done[c] = 0; m_half[c] = 0; m_err[c] = 0; end
        @(negedge clk);
        ev_err = '1; // events under reset must not stick
        tick("R10 reset");
        tick("R10 reset");
        check("R10 irq after reset", DW'(irq), '0);
        rst_n = 1'b1;
        idle_inputs();
        tick("R10 idle");

        // R1: event with all enables off still sets the flag; irq stays low (R7).
        ev_done[0] = 1'b1;
        tick("R1");
        idle_inputs();
        bus_addr = 1'b0;
        tick("R1");
        check("R1 R2 status ch0 complete", bus_rdata, 32'h0000_0003);
        check("R7 irq with enables off", DW'(irq), '0);

        // R6: matching enable fires; enable bit 0 fires on any flag; a wrong bit does not.
        int_en = FW'(4'b0010);
        tick("R6");
        check("R6 irq on complete enable", DW'(irq[0]), 1);
        int_en = FW'(4'b0100);
        tick("R6");
        check("R6 irq off with half enable only", DW'(irq[0]), 0);
        int_en = FW'(4'b0001);
        tick("R6");
        check("R6 irq on summary enable", DW'(irq[0]), 1);
        int_en = '0;
        tick("R7");
        check("R7 flags kept after enables cleared", bus_rdata, 32'h0000_0003);

        // R3: clearing an unset position keeps the flag; the matching position clears it.
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h0000_0004;
        tick("R3");
        bus_wr = 1'b0; bus_addr = 1'b0;
        tick("R3");
        check("R3 unrelated clear keeps flag", bus_rdata, 32'h0000_0003);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h0000_0002;
        tick("R3");
        bus_wr = 1'b0; bus_addr = 1'b0;
        tick("R3");
        check("R3 matching clear removes flag", bus_rdata, 32'h0000_0000);

        // R8: precedence on channel 2 with all three flags set.
        ev_half[2] = 1'b1; ev_err[2] = 1'b1; ev_done[2] = 1'b1;
        cause_sel = 3'd2;
        tick("R8");
        idle_inputs();
        tick("R8");
        check("R8 error wins", DW'(cause_code), 3);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h0000_0800;
        tick("R8");
        bus_wr = 1'b0; bus_addr = 1'b0;
        tick("R8");
        check("R8 complete over half", DW'(cause_code), 2);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h0000_0200;
        tick("R8");
        bus_wr = 1'b0; bus_addr = 1'b0;
        tick("R8");
        check("R8 half alone", DW'(cause_code), 1);

        // R4: summary-position clear removes every flag of channel 2.
        ev_err[2] = 1'b1; ev_done[2] = 1'b1;
        tick("R4");
        idle_inputs();
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h0000_0100;
        tick("R4");
        bus_wr = 1'b0; bus_addr = 1'b0;
        tick("R4");
        check("R4 whole channel cleared", bus_rdata, 32'h0000_0000);

        // R5: error event on channel 3 in the same cycle as its clear.
        ev_err[3] = 1'b1;
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h0000_F000;
        tick("R5");
        idle_inputs(); bus_addr = 1'b0;
        tick("R5");
        check("R5 event beats clear", bus_rdata, 32'h0000_9000);

        // R9: status address writes are ignored; clear address reads zero.
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = '1;
        tick("R9");
        bus_wr = 1'b0;
        tick("R9");
        check("R9 status write ignored", bus_rdata, 32'h0000_9000);
        bus_addr = 1'b1;
        tick("R9");
        check("R9 clear address reads zero", bus_rdata, '0);

        // R8: channel select beyond the last channel.
        cause_sel = 3'd7; ev_err = '1;
        tick("R8");
        idle_inputs();
        tick("R8");
        check("R8 unknown channel gives none", DW'(cause_code), 0);

        // Mixed traffic, model compared every cycle.
        for (int i = 0; i < 4000; i++) begin
            ev_done   = NC'($urandom & $urandom);
            ev_half   = NC'($urandom & $urandom);
            ev_err    = NC'($urandom & $urandom & $urandom);
            int_en    = FW'($urandom);
            bus_wr    = ($urandom % 3) == 0;
            bus_addr  = 1'($urandom);
            bus_wdata = $urandom | ($urandom & $urandom);
            cause_sel = SW'($urandom);
            tick("R1 R3 R4 R5 mixed");
        end

        // R10: reset in mid-run clears everything.
        idle_inputs(); int_en = '1; bus_addr = 1'b0;
        rst_n = 1'b0;
        tick("R10");
        rst_n = 1'b1;
        tick("R10");
        check("R10 status after reset", bus_rdata, '0);
        check("R10 irq after reset", DW'(irq), '0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule